// File: doc/BRIEF.md
# Magnetic Sensor Coil Pulse Sequencer

This block turns the two coil-pulse request bits of a magnetic sensor's control register into timed, polarity-correct drive enables for the high-current coil that restores the sensing film's magnetization. A request in the "forward" direction magnetizes the film one way. A request in the "reverse" direction pushes current the other way. When both bits are set, the forward action wins. Each request ends with a one-cycle completion strobe, which the register logic uses to clear the bit.

The sequencer also applies the ordering rules that protect the coil driver's charge reservoir. It ignores all requests during a start-up quiet period after power-on reset. The first accepted action after power-up must be forward. In low-supply mode, actions must alternate direction, and a recharge interval must pass between pulses. A request that is refused still produces the completion strobe, so the bit never stays stuck. All durations are counted in ticks of an external timebase strobe.

Top module: `coil_pulse_ctrl`

## Requirements
- R1: During and directly after reset, `drv_fwd`, `drv_rev`, `busy` and `done` are all 0.
- R2: An accepted forward request (`rq_fwd`=1) raises `drv_fwd` for exactly PULSE_TICKS tick strobes. The strobe `done` then pulses for one cycle.
- R3: An accepted reverse request (`rq_rev`=1, `rq_fwd`=0) raises `drv_rev` for exactly PULSE_TICKS tick strobes, followed by `done`.
- R4: With both request bits at 1 in the same cycle, only a forward pulse is produced.
- R5: A request made before POWERUP_TICKS tick strobes have passed since reset drives no coil but still yields `done`.
- R6: A reverse request made before any pulse has been accepted since reset drives no coil but still yields `done`.
- R7: With `low_supply`=1, a request of the same direction as the last accepted pulse drives no coil but still yields `done`.
- R8: With `low_supply`=1, at least RECOVER_TICKS tick strobes elapse between the end of one pulse and the start of the next.
- R9: `drv_fwd` and `drv_rev` are never 1 together. With `low_supply`=0, a change of direction leaves at least one tick strobe with both enables low.
- R10: `done` is never high in two consecutive cycles, and `busy` is 1 whenever a drive enable is 1.
- R11: With `low_supply`=0, repeated requests of the same direction are each performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick | input | 1 | Timebase strobe, one cycle wide |
| rq_fwd | input | 1 | Forward (set) pulse request bit |
| rq_rev | input | 1 | Reverse (reset) pulse request bit |
| low_supply | input | 1 | Low-supply mode: alternation and recharge rules apply |
| drv_fwd | output | 1 | Coil drive enable, forward polarity |
| drv_rev | output | 1 | Coil drive enable, reverse polarity |
| busy | output | 1 | A request is being handled |
| done | output | 1 | One-cycle completion strobe that clears the request |

## Verification
Two decisions can land in the same cycle: the priority choice between simultaneous forward and reverse bits, and the low-supply alternation verdict. The bench raises both bits together right after a reverse pulse, so the forward choice is also a legal alternation. It judges the result by which enable rises and by the pulse length counted in tick strobes. The bench also places a refused same-direction request straight after an accepted one in low-supply mode. It expects a bare `done` with no drive, and a correct recharge gap before the next allowed pulse.

// File: rtl/coil_pkg.sv
package coil_pkg;

    typedef enum logic [1:0] {
        POL_NONE = 2'd0,
        POL_FWD  = 2'd1,
        POL_REV  = 2'd2
    } pol_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_PULSE = 2'd2,
        ST_DONE  = 2'd3
    } seq_st_t;

    typedef struct packed {
        logic accept;
        pol_t pol;
    } verdict_t;

    // Forward wins over reverse; refusal rules for cold start, first
    // command and low-supply repetition.
    function automatic verdict_t judge(logic want_fwd, logic want_rev,
                                       logic lowv, logic warm, pol_t last);
        verdict_t v;
        v.pol    = want_fwd ? POL_FWD : (want_rev ? POL_REV : POL_NONE);
        v.accept = 1'b1;
        if (!warm)                                  v.accept = 1'b0;
        if (v.pol == POL_REV && last == POL_NONE)   v.accept = 1'b0;
        if (lowv && v.pol == last)                  v.accept = 1'b0;
        if (v.pol == POL_NONE)                      v.accept = 1'b0;
        return v;
    endfunction

    // Tick strobes required between the previous pulse end and this one.
    function automatic logic [31:0] gap_need(pol_t pol, pol_t last,
                                             logic lowv, logic [31:0] recover);
        if (last == POL_NONE) return 32'd0;
        if (lowv)             return recover;
        return (pol != last) ? 32'd1 : 32'd0;
    endfunction

endpackage

// File: rtl/coil_warmup.sv
module coil_warmup #(
    parameter int POWERUP_TICKS = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic warm
);
    localparam int CW = $clog2(POWERUP_TICKS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick && cnt != CW'(POWERUP_TICKS)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign warm = (cnt == CW'(POWERUP_TICKS));

    p_warm_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        warm |=> warm);

endmodule

// File: rtl/coil_gap_timer.sv
module coil_gap_timer #(
    parameter int RECOVER_TICKS = 5000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic restart,
    output logic [$clog2(RECOVER_TICKS + 1)-1:0] gap_cnt
);
    localparam int GW = $clog2(RECOVER_TICKS + 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt <= GW'(RECOVER_TICKS);
        end else if (restart) begin
            gap_cnt <= '0;
        end else if (tick && gap_cnt != GW'(RECOVER_TICKS)) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    p_gap_sat_r8: assert property (@(posedge clk) disable iff (rst)
        gap_cnt <= GW'(RECOVER_TICKS));

endmodule

// File: rtl/coil_seq.sv
module coil_seq
    import coil_pkg::*;
#(
    parameter int PULSE_TICKS   = 20,
    parameter int RECOVER_TICKS = 5000,
    localparam int GW = $clog2(RECOVER_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          rq_fwd,
    input  logic          rq_rev,
    input  logic          low_supply,
    input  logic          warm,
    input  logic [GW-1:0] gap_cnt,
    output logic          gap_restart,
    output logic          drv_fwd,
    output logic          drv_rev,
    output logic          busy,
    output logic          done
);
    localparam int PW = $clog2(PULSE_TICKS + 1);

    seq_st_t       st;
    pol_t          pol_q;
    pol_t          last_q;
    logic [GW-1:0] need_q;
    logic [PW-1:0] pcnt;
    verdict_t      v;
    logic [31:0]   need_w;
    logic          pulse_end;

    always_comb begin
        v      = judge(rq_fwd, rq_rev, low_supply, warm, last_q);
        need_w = gap_need(v.pol, last_q, low_supply, 32'(RECOVER_TICKS));
    end

    assign pulse_end = (st == ST_PULSE) && tick && (pcnt == PW'(PULSE_TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            pol_q  <= POL_NONE;
            last_q <= POL_NONE;
            need_q <= '0;
            pcnt   <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (rq_fwd || rq_rev) begin
                        if (v.accept) begin
                            pol_q  <= v.pol;
                            last_q <= v.pol;
                            need_q <= GW'(need_w);
                            st     <= ST_WAIT;
                        end else begin
                            st <= ST_DONE;
                        end
                    end
                end
                ST_WAIT: begin
                    if (gap_cnt >= need_q) begin
                        pcnt <= '0;
                        st   <= ST_PULSE;
                    end
                end
                ST_PULSE: begin
                    if (pulse_end) begin
                        st <= ST_DONE;
                    end else if (tick) begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                ST_DONE: begin
                    pol_q <= POL_NONE;
                    st    <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign gap_restart = pulse_end;
    assign drv_fwd     = (st == ST_PULSE) && (pol_q == POL_FWD);
    assign drv_rev     = (st == ST_PULSE) && (pol_q == POL_REV);
    assign busy        = (st != ST_IDLE);
    assign done        = (st == ST_DONE);

    p_no_overlap_r9: assert property (@(posedge clk) disable iff (rst)
        !(drv_fwd && drv_rev));

    p_turn_gap_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_rev) |-> !$past(drv_fwd));

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_drive_r10: assert property (@(posedge clk) disable iff (rst)
        (drv_fwd || drv_rev) |-> busy);

    p_cold_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (drv_fwd || drv_rev) |-> warm);

    p_recover_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(drv_fwd || drv_rev) |-> (gap_cnt >= need_q));

endmodule

// File: rtl/coil_pulse_ctrl.sv
module coil_pulse_ctrl #(
    parameter int PULSE_TICKS   = 20,
    parameter int RECOVER_TICKS = 5000,
    parameter int POWERUP_TICKS = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rq_fwd,
    input  logic rq_rev,
    input  logic low_supply,
    output logic drv_fwd,
    output logic drv_rev,
    output logic busy,
    output logic done
);
    localparam int GW = $clog2(RECOVER_TICKS + 1);

    logic          warm;
    logic          gap_restart;
    logic [GW-1:0] gap_cnt;

    coil_warmup #(.POWERUP_TICKS(POWERUP_TICKS)) u_warm (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .warm (warm)
    );

    coil_gap_timer #(.RECOVER_TICKS(RECOVER_TICKS)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .restart (gap_restart),
        .gap_cnt (gap_cnt)
    );

    coil_seq #(
        .PULSE_TICKS   (PULSE_TICKS),
        .RECOVER_TICKS (RECOVER_TICKS)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .rq_fwd      (rq_fwd),
        .rq_rev      (rq_rev),
        .low_supply  (low_supply),
        .warm        (warm),
        .gap_cnt     (gap_cnt),
        .gap_restart (gap_restart),
        .drv_fwd     (drv_fwd),
        .drv_rev     (drv_rev),
        .busy        (busy),
        .done        (done)
    );

endmodule

// File: tb/sim_coil_pulse_ctrl.sv
`timescale 1ns/1ps
module sim_coil_pulse_ctrl;
    localparam int PT = 4;
    localparam int RT = 12;
    localparam int WT = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic rq_fwd = 1'b0;
    logic rq_rev = 1'b0;
    logic low_supply = 1'b0;
    logic drv_fwd, drv_rev, busy, done;

    int checks = 0;
    int failures = 0;

    typedef struct {
        int    pol;      // 0 none, 1 forward, 2 reverse
        int    min_gap;
        string tag;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    coil_pulse_ctrl #(.PULSE_TICKS(PT), .RECOVER_TICKS(RT), .POWERUP_TICKS(WT)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .rq_fwd(rq_fwd), .rq_rev(rq_rev),
        .low_supply(low_supply), .drv_fwd(drv_fwd), .drv_rev(drv_rev),
        .busy(busy), .done(done)
    );

    initial forever begin
        @(negedge clk);
        tick = ~tick;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic issue(input logic f, input logic r, input int pol,
                         input int min_gap, input string tag);
        exp_t e;
        e.pol = pol; e.min_gap = min_gap; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        rq_fwd = f;
        rq_rev = r;
        do @(negedge clk); while (!done);
        rq_fwd = 1'b0;
        rq_rev = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Monitor / scoreboard
    int  obs_pol = 0;
    int  pulse_ticks = 0;
    int  gap_ticks = 999;
    bit  prev_drv = 1'b0;
    bit  prev_done = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            automatic bit drv = drv_fwd | drv_rev;
            if (drv_fwd && drv_rev) check(1'b0, "R9 overlap", 1, 0);
            if (drv && !busy) check(1'b0, "R10 busy", 0, 1);
            if (drv && !prev_drv) begin
                obs_pol = drv_fwd ? 1 : 2;
                pulse_ticks = 0;
                if (q.size() > 0)
                    check(gap_ticks >= q[0].min_gap, {q[0].tag, " gap"}, gap_ticks, q[0].min_gap);
            end
            if (!drv && prev_drv) gap_ticks = 0;
            if (tick) begin
                if (drv) pulse_ticks++;
                else if (gap_ticks < 999) gap_ticks++;
            end
            if (done) begin
                if (prev_done) check(1'b0, "R10 done width", 2, 1);
                if (q.size() == 0) begin
                    check(1'b0, "R10 unexpected done", 1, 0);
                end else begin
                    automatic exp_t e = q.pop_front();
                    check(obs_pol == e.pol, {e.tag, " polarity"}, obs_pol, e.pol);
                    if (e.pol != 0)
                        check(pulse_ticks == PT, {e.tag, " width"}, pulse_ticks, PT);
                end
                obs_pol = 0;
            end
            prev_drv = drv;
            prev_done = done;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(drv_fwd == 0, "R1 drv_fwd", drv_fwd, 0);
        check(drv_rev == 0, "R1 drv_rev", drv_rev, 0);
        check(busy == 0, "R1 busy", busy, 0);
        check(done == 0, "R1 done", done, 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 0 && done == 0, "R1 after release", busy, 0);

        issue(1, 0, 0, 0, "R5 cold forward");
        repeat (50) @(negedge clk);
        issue(0, 1, 0, 0, "R6 first reverse");
        issue(1, 0, 1, 0, "R2 forward");
        issue(1, 0, 1, 0, "R11 repeat forward");
        issue(0, 1, 2, 1, "R3 reverse");
        issue(1, 1, 1, 1, "R4 both bits");
        low_supply = 1'b1;
        issue(1, 0, 0, 0, "R7 lv repeat forward");
        issue(0, 1, 2, RT, "R8 lv reverse");
        issue(0, 1, 0, 0, "R7 lv repeat reverse");
        issue(1, 0, 1, RT, "R8 lv forward");
        repeat (5) @(negedge clk);
        check(q.size() == 0, "R10 all done seen", q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule